// File: doc/BRIEF.md
# Amplitude-Gated Six-Channel Zero-Crossing Flagger

This block watches six signed sample streams (three phase voltages and three phase currents) and flags the moments when a stream changes sign. Samples arrive together, one word per channel, and are accepted when a shared strobe is high. A crossing is a change in the sign bit between two consecutive accepted samples of the same channel.

Voltage channels are gated against noise. Each voltage channel tracks the largest magnitude seen since its last sign change. A crossing on a voltage channel is reported only when that peak reaches one tenth of a full-scale value supplied on an input port. Current channels report every crossing, whatever the amplitude.

Each channel owns one sticky flag in a 32-bit status word. A mask word selects which flags pull the active-low interrupt output down. Software clears flags by writing ones to them, and it writes the mask through the same port.

Top module: `zc_monitor`

## Requirements
- R1: A crossing is a sign-bit difference between the current accepted sample and the previous accepted sample of the same channel. Nothing happens while smp_valid is low. The first accepted sample after reset never produces an event.
- R2: A voltage-channel crossing produces an event only if the peak absolute value of the samples accepted since the previous sign change, up to but not including the crossing sample, is at least floor(full_scale/10).
- R3: A current-channel crossing always produces an event, even for amplitudes as small as 1 LSB.
- R4: Events on voltage A, B and C set status bits 9, 10 and 11. Events on current A, B and C set status bits 12, 13 and 14. A bit is visible on the clock edge that accepts the crossing sample.
- R5: irq_n is low exactly when some bit is 1 in both status and mask. It follows these registers with no added delay.
- R6: A write with wr_sel=0 clears every status bit where wr_data holds a 1. Bits where wr_data holds a 0 are unchanged.
- R7: A write with wr_sel=1 loads the mask. Bit 0 and every bit outside 9..14 read as zero in both status and mask.
- R8: An event that arrives in the same cycle as a clear of the same bit leaves that bit set.
- R9: A set flag stays set until it is cleared, regardless of later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Accept the six sample words this cycle |
| v_a | input | SW | Voltage phase A sample, two's complement |
| v_b | input | SW | Voltage phase B sample |
| v_c | input | SW | Voltage phase C sample |
| i_a | input | SW | Current phase A sample |
| i_b | input | SW | Current phase B sample |
| i_c | input | SW | Current phase C sample |
| full_scale | input | SW | Unsigned full-scale magnitude; the gate threshold is one tenth of it |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: clear status bits (write-one-to-clear); 1: load mask |
| wr_data | input | 32 | Write data |
| status | output | 32 | Sticky crossing flags |
| mask | output | 32 | Interrupt enable per flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check several rules on every cycle. An event needs a crossing. A voltage event needs the gate to be open. A current crossing always becomes an event. Flags are sticky and win over a same-cycle clear. Cleared bits drop. The interrupt level matches status and mask, and unused bits stay zero. Only the bench scenarios can show that the gate threshold sits exactly at one tenth of full scale for both polarities, that the peak resets at each sign change, that each channel reaches its own bit, and that the first sample after reset and idle cycles raise nothing.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int STAT_W = 32;
  localparam int N_PH   = 3;
  localparam int N_CH   = 2 * N_PH;
  localparam int V_BASE = 9;
  localparam int I_BASE = 12;

  // status bit owned by channel k (0..2 voltage, 3..5 current)
  function automatic int chan_bit(input int k);
    return (k < N_PH) ? (V_BASE + k) : (I_BASE + k - N_PH);
  endfunction

  function automatic logic [STAT_W-1:0] impl_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int k = 0; k < N_CH; k++) m[chan_bit(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/zc_chan.sv
module zc_chan #(
  parameter int SW    = 24,
  parameter bit GATED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [SW-1:0] smp,
  input  logic [SW-1:0] thr,
  output logic          xing,
  output logic          gate_ok,
  output logic          evt
);
  logic          primed_q;
  logic          sgn_q;
  logic [SW-1:0] pk_q;
  logic [SW-1:0] mag_w;
  logic          cmp_w;

  function automatic logic [SW-1:0] mag_of(input logic [SW-1:0] x);
    logic [SW-1:0] r;
    r = x[SW-1] ? (~x + 1'b1) : x;
    return r;
  endfunction

  assign mag_w   = mag_of(smp);
  assign cmp_w   = (pk_q >= thr);
  assign xing    = valid & primed_q & (smp[SW-1] != sgn_q);
  assign gate_ok = GATED ? cmp_w : 1'b1;
  assign evt     = xing & gate_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      sgn_q    <= 1'b0;
      pk_q     <= '0;
    end else if (valid) begin
      if (!primed_q || (smp[SW-1] != sgn_q)) begin
        primed_q <= 1'b1;
        sgn_q    <= smp[SW-1];
        pk_q     <= mag_w;
      end else if (mag_w > pk_q) begin
        pk_q <= mag_w;
      end
    end
  end
endmodule

// File: rtl/zc_flags.sv
module zc_flags
  import zc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] keep_vec,
  output logic              irq_n
);
  localparam logic [STAT_W-1:0] IMPL = impl_mask();

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mask_q;

  assign clr_vec  = (wr_en && !wr_sel) ? (wr_data & IMPL) : '0;
  assign keep_vec = stat_q & ~clr_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (keep_vec | set_vec) & IMPL;
      if (wr_en && wr_sel) mask_q <= wr_data & IMPL;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq_n  = ~|(stat_q & mask_q);
endmodule

// File: rtl/zc_monitor.sv
module zc_monitor
  import zc_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SW-1:0]     v_a,
  input  logic [SW-1:0]     v_b,
  input  logic [SW-1:0]     v_c,
  input  logic [SW-1:0]     i_a,
  input  logic [SW-1:0]     i_b,
  input  logic [SW-1:0]     i_c,
  input  logic [SW-1:0]     full_scale,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq_n
);
  function automatic logic [SW-1:0] tenth(input logic [SW-1:0] fs);
    return fs / 10;
  endfunction

  logic [SW-1:0]     smp_arr [N_CH];
  logic [SW-1:0]     thr_w;
  logic [N_CH-1:0]   xing_vec;
  logic [N_CH-1:0]   gate_ok_vec;
  logic [N_CH-1:0]   evt_vec;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] keep_vec;

  assign thr_w      = tenth(full_scale);
  assign smp_arr[0] = v_a;
  assign smp_arr[1] = v_b;
  assign smp_arr[2] = v_c;
  assign smp_arr[3] = i_a;
  assign smp_arr[4] = i_b;
  assign smp_arr[5] = i_c;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    zc_chan #(.SW(SW), .GATED(k < N_PH)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (smp_valid),
      .smp     (smp_arr[k]),
      .thr     (thr_w),
      .xing    (xing_vec[k]),
      .gate_ok (gate_ok_vec[k]),
      .evt     (evt_vec[k])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < N_CH; k++) set_vec[chan_bit(k)] = evt_vec[k];
  end

  zc_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .status   (status),
    .mask     (mask),
    .clr_vec  (clr_vec),
    .keep_vec (keep_vec),
    .irq_n    (irq_n)
  );
endmodule

// File: rtl/zc_monitor_chk.sv
module zc_monitor_chk
  import zc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [N_CH-1:0]   xing_vec,
  input logic [N_CH-1:0]   gate_ok_vec,
  input logic [N_CH-1:0]   evt_vec,
  input logic [STAT_W-1:0] set_vec,
  input logic [STAT_W-1:0] clr_vec,
  input logic [STAT_W-1:0] keep_vec,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] mask,
  input logic              irq_n
);
  localparam logic [STAT_W-1:0] IMPL = impl_mask();

  p_evt_needs_xing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec & ~xing_vec) == '0);

  p_volt_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec[N_PH-1:0] & ~gate_ok_vec[N_PH-1:0]) == '0);

  p_curr_ungated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xing_vec[N_CH-1:N_PH] & ~evt_vec[N_CH-1:N_PH]) == '0);

  p_event_sets_r4_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_vec)) == $past(set_vec)));

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & mask)) == !irq_n);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_vec & ~set_vec)) == '0));

  p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status | mask) & ~IMPL) == '0);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(keep_vec)) == $past(keep_vec)));
endmodule

bind zc_monitor zc_monitor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xing_vec    (xing_vec),
  .gate_ok_vec (gate_ok_vec),
  .evt_vec     (evt_vec),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .keep_vec    (keep_vec),
  .status      (status),
  .mask        (mask),
  .irq_n       (irq_n)
);

// File: tb/tb_zc_monitor.sv
module tb_zc_monitor;
  localparam int SW = 24;
  localparam int FS = 1000;
  localparam int THR = FS / 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [SW-1:0] s [6];
  logic [SW-1:0] full_scale = SW'(FS);
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] status, mask;
  logic irq_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zc_monitor #(.SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .v_a(s[0]), .v_b(s[1]), .v_c(s[2]), .i_a(s[3]), .i_b(s[4]), .i_c(s[5]),
    .full_scale(full_scale), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status(status), .mask(mask), .irq_n(irq_n)
  );

  function automatic int bit_of(input int k);
    return (k < 3) ? 9 + k : 12 + (k - 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk); smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  // drive channel k to a fresh half cycle of polarity pol and amplitude a, then cross
  task automatic gate_case(input int k, input int a, input int pol);
    logic [31:0] exp;
    s[k] = SW'(-pol); pulse();
    s[k] = SW'(pol);  pulse();
    s[k] = SW'(pol * a); pulse();
    wr(1'b0, 32'hFFFF_FFFF);
    s[k] = SW'(-pol); pulse();
    exp = '0;
    if (k >= 3 || a >= THR) exp[bit_of(k)] = 1'b1;
    if (k < 3) check("R2 voltage gate", status, exp);
    else       check("R3 current ungated", status, exp);
    wr(1'b0, 32'hFFFF_FFFF);
  endtask

  initial begin
    for (int k = 0; k < 6; k++) s[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset status", status, 32'h0);
    check("R7 reset mask", mask, 32'h0);
    check("R5 reset irq_n", {31'h0, irq_n}, 32'h1);

    // R1: first sample primes only
    s[0] = SW'(-500); pulse();
    check("R1 first sample no event", status, 32'h0);
    // R1: no valid, no event
    s[0] = SW'(500);
    repeat (4) @(negedge clk);
    check("R1 idle no event", status, 32'h0);
    pulse();
    check("R4 voltage A bit 9", status, 32'h0000_0200);
    // R9 sticky under non-crossing samples
    s[0] = SW'(700); pulse(); pulse();
    check("R9 sticky", status, 32'h0000_0200);
    wr(1'b0, 32'hFFFF_FFFF);
    check("R6 clear all", status, 32'h0);

    // R2/R3 sweeps per channel, both polarities
    for (int k = 0; k < 3; k++)
      for (int a = THR - 6; a <= THR + 6; a++) begin
        gate_case(k, a, 1);
        gate_case(k, a, -1);
      end
    for (int k = 3; k < 6; k++) begin
      gate_case(k, 1, 1);
      gate_case(k, 1, -1);
      gate_case(k, 3, 1);
      gate_case(k, FS, -1);
    end

    // R4 mapping of all channels at once: every channel crosses together
    for (int k = 0; k < 6; k++) s[k] = SW'(-1); pulse();
    for (int k = 0; k < 6; k++) s[k] = SW'(1);  pulse();
    for (int k = 0; k < 6; k++) s[k] = SW'(-500); pulse();
    wr(1'b0, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) s[k] = SW'(1); pulse();
    check("R4 all six bits", status, 32'h0000_7E00);
    wr(1'b0, 32'hFFFF_FFFF);

    // R7 mask storage and unused bits
    wr(1'b1, 32'hFFFF_FFFF);
    check("R7 mask unused bits zero", mask, 32'h0000_7E00);
    wr(1'b1, 32'h0);

    // R5 interrupt routing with current B flag (bit 13)
    s[4] = SW'(-1); pulse();
    check("R4 current B bit 13", status, 32'h0000_2000);
    check("R5 masked off irq high", {31'h0, irq_n}, 32'h1);
    wr(1'b1, 32'h0000_2000);
    check("R5 unmasked irq low", {31'h0, irq_n}, 32'h0);
    wr(1'b1, 32'h0000_1000);
    check("R5 other mask irq high", {31'h0, irq_n}, 32'h1);
    wr(1'b1, 32'h0000_2000);
    wr(1'b0, 32'hFFFF_DFFF);
    check("R6 zero bits keep flag", status, 32'h0000_2000);
    wr(1'b0, 32'h0000_2000);
    check("R6 one clears flag", status, 32'h0);
    check("R5 irq released", {31'h0, irq_n}, 32'h1);

    // R8 event and clear in the same cycle
    s[4] = SW'(1);
    @(negedge clk); smp_valid = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_2000;
    @(negedge clk); smp_valid = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R8 event wins over clear", status, 32'h0000_2000);
    check("R8 irq low", {31'h0, irq_n}, 32'h0);
    wr(1'b0, 32'h0000_2000);
    check("R6 final clear", status, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule